// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is a configurable arithmetic slice for filter taps, dot products and wide accumulators. An 18-bit pre-adder can merge two operands before a signed 18x18 multiplier. A 48-bit post-adder/subtractor then combines the sign-extended product, or a packed concatenation of the operands, with zero, a wide C operand, a cascade input from a neighbouring slice, or its own registered result. The last of these makes it an accumulator.

A 7-bit mode word picks the route on every cycle. Bits [1:0] select the X operand: 0 = zero, 1 = product, 2 = P, 3 = {d[11:0], a, b}. Bits [3:2] select the Z operand: 0 = zero, 1 = cascade input, 2 = P, 3 = C. Bit 4 enables the pre-adder. Bit 5 makes the pre-adder subtract (d - b) instead of adding (d + b). Bit 6 makes the post-adder compute Z - (X + carry) instead of Z + X + carry.

Slices are chained through two paths. The multiplier's B operand leaves on a cascade output, and P leaves on a cascade output that feeds the next slice's cascade input. The register stages are chosen at compile time: an input stage, a product stage and the output stage. Each stage has its own clock enable and its own synchronous clear.

Top module: `mac_slice`

## Requirements
- R1: With X = product and Z = zero, P equals the signed 18x18 product of a and the multiplier operand, sign-extended to 48 bits.
- R2: With mode bit 4 set and bit 5 clear, the multiplier operand is (d + b), wrapped to 18 bits.
- R3: With mode bits 4 and 5 both set, the multiplier operand is (d - b), wrapped to 18 bits.
- R4: With mode bit 4 clear, the multiplier operand is b, and d has no effect on the product.
- R5: With mode bit 6 set, P = Z - X - carry.
- R6: With Z = P, each new result adds to the previous registered P, so a run of products accumulates.
- R7: With X = 3, the X operand is {d[11:0], a[17:0], b[17:0]}.
- R8: With Z = 3, the Z operand is the C input. With Z = 1, the Z operand is the cascade input, which is not delayed inside the slice.
- R9: The carry input adds one to the result in add mode.
- R10: The P cascade output always equals p_o. bcout_o carries the multiplier operand one clock after the inputs are taken.
- R11: With the default parameters, a result appears on p_o three rising edges after its inputs are presented.
- R12: All post-adder arithmetic wraps modulo 2^48, with no saturation.
- R13: When a stage's clock enable is low, that stage holds its value. A synchronous clear empties that stage at the next edge, whatever its clock enable.
- R14: While rst_ni is low, p_o and bcout_o read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_in_i | input | 1 | Clock enable for the input stage |
| ce_m_i | input | 1 | Clock enable for the product stage |
| ce_p_i | input | 1 | Clock enable for the output stage |
| srst_in_i | input | 1 | Synchronous clear for the input stage |
| srst_m_i | input | 1 | Synchronous clear for the product stage |
| srst_p_i | input | 1 | Synchronous clear for the output stage |
| mode_i | input | 7 | Route and operation select |
| a_i | input | 18 | Multiplier operand A |
| b_i | input | 18 | Operand B, input to the pre-adder |
| d_i | input | 18 | Operand D, input to the pre-adder |
| c_i | input | 48 | Wide post-adder operand |
| carry_i | input | 1 | Post-adder carry in |
| pcin_i | input | 48 | Cascade input from the previous slice |
| bcout_o | output | 18 | Multiplier B operand, for chaining |
| p_o | output | 48 | Result |
| pcout_o | output | 48 | Result, for chaining |

## Verification
The bench builds the slice with its defaults: the input and product stages are both present, giving a three-edge latency, and the output register is always present. With every stage present, the per-stage clock enables and synchronous clears can each be shown to hold or empty a stage that is visible at the ports. The bench streams one operation per cycle, so accumulation runs back to back and feeds the registered P straight into the next sum. It also covers the corner cases: the most negative operands, pre-adder wrap and 48-bit wrap.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned OPW = 18;
  localparam int unsigned PRW = 2 * OPW;
  localparam int unsigned ACW = 48;
  localparam int unsigned CTW = ACW - 2 * OPW;

  typedef enum logic [1:0] {X_ZERO, X_PROD, X_P, X_CAT} xsel_e;
  typedef enum logic [1:0] {Z_ZERO, Z_PCIN, Z_P, Z_C} zsel_e;

  typedef struct packed {
    logic  post_sub;
    logic  pre_sub;
    logic  pre_en;
    zsel_e zsel;
    xsel_e xsel;
  } mode_t;

  typedef struct packed {
    mode_t          mode;
    logic           cin;
    logic [ACW-1:0] c;
    logic [OPW-1:0] d;
    logic [OPW-1:0] a;
    logic [OPW-1:0] b;
  } in_stage_t;

  typedef struct packed {
    logic           post_sub;
    zsel_e          zsel;
    xsel_e          xsel;
    logic           cin;
    logic [ACW-1:0] c;
    logic [ACW-1:0] cat;
    logic [PRW-1:0] prod;
  } m_stage_t;
endpackage

// File: rtl/mac_pipe_reg.sv
module mac_pipe_reg #(
  parameter int unsigned W  = 8,
  parameter bit          EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_i,
  input  logic         srst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (EN) begin : g_reg
    logic [W-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_q <= '0;
      else if (srst_i) q_q <= '0;
      else if (ce_i)   q_q <= d_i;
    end
    assign q_o = q_q;
  end else begin : g_wire
    assign q_o = d_i;
  end
endmodule

// File: rtl/mac_preadd.sv
module mac_preadd
  import mac_pkg::*;
(
  input  logic           en_i,
  input  logic           sub_i,
  input  logic [OPW-1:0] d_i,
  input  logic [OPW-1:0] b_i,
  output logic [OPW-1:0] m_o
);
  always_comb begin
    if (!en_i)     m_o = b_i;
    else if (sub_i) m_o = d_i - b_i;
    else           m_o = d_i + b_i;
  end
endmodule

// File: rtl/mac_postadd.sv
module mac_postadd
  import mac_pkg::*;
(
  input  xsel_e          xsel_i,
  input  zsel_e          zsel_i,
  input  logic           sub_i,
  input  logic           cin_i,
  input  logic [PRW-1:0] prod_i,
  input  logic [ACW-1:0] cat_i,
  input  logic [ACW-1:0] c_i,
  input  logic [ACW-1:0] pcin_i,
  input  logic [ACW-1:0] p_i,
  output logic [ACW-1:0] s_o
);
  logic [ACW-1:0] x_op, z_op, prod_ext, cin_ext;

  assign prod_ext = {{(ACW-PRW){prod_i[PRW-1]}}, prod_i};
  assign cin_ext  = {{(ACW-1){1'b0}}, cin_i};

  always_comb begin
    unique case (xsel_i)
      X_PROD:  x_op = prod_ext;
      X_P:     x_op = p_i;
      X_CAT:   x_op = cat_i;
      default: x_op = '0;
    endcase
    unique case (zsel_i)
      Z_PCIN:  z_op = pcin_i;
      Z_P:     z_op = p_i;
      Z_C:     z_op = c_i;
      default: z_op = '0;
    endcase
  end

  // wraps modulo 2^ACW
  assign s_o = sub_i ? (z_op - x_op - cin_ext) : (z_op + x_op + cin_ext);
endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_pkg::*;
#(
  parameter bit IN_REG = 1'b1,
  parameter bit M_REG  = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ce_in_i,
  input  logic           ce_m_i,
  input  logic           ce_p_i,
  input  logic           srst_in_i,
  input  logic           srst_m_i,
  input  logic           srst_p_i,
  input  logic [6:0]     mode_i,
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  input  logic [OPW-1:0] d_i,
  input  logic [ACW-1:0] c_i,
  input  logic           carry_i,
  input  logic [ACW-1:0] pcin_i,
  output logic [OPW-1:0] bcout_o,
  output logic [ACW-1:0] p_o,
  output logic [ACW-1:0] pcout_o
);
  localparam int unsigned IW = $bits(in_stage_t);
  localparam int unsigned MW = $bits(m_stage_t);

  in_stage_t      in_d, in_q;
  m_stage_t       m_d, m_q;
  logic [OPW-1:0] mul_b;
  logic [ACW-1:0] sum, p_q;
  logic signed [PRW-1:0] prod;

  logic  post_sub, post_cin;
  xsel_e post_x;
  zsel_e post_z;

  assign in_d = '{mode: mode_t'(mode_i), cin: carry_i, c: c_i, d: d_i, a: a_i, b: b_i};

  mac_pipe_reg #(.W(IW), .EN(IN_REG)) u_in_reg (
    .clk_i, .rst_ni, .ce_i(ce_in_i), .srst_i(srst_in_i), .d_i(in_d), .q_o(in_q)
  );

  mac_preadd u_preadd (
    .en_i(in_q.mode.pre_en), .sub_i(in_q.mode.pre_sub),
    .d_i(in_q.d), .b_i(in_q.b), .m_o(mul_b)
  );

  assign prod    = $signed(in_q.a) * $signed(mul_b);
  assign bcout_o = mul_b;

  assign m_d = '{post_sub: in_q.mode.post_sub, zsel: in_q.mode.zsel, xsel: in_q.mode.xsel,
                 cin: in_q.cin, c: in_q.c, cat: {in_q.d[CTW-1:0], in_q.a, in_q.b},
                 prod: prod};

  mac_pipe_reg #(.W(MW), .EN(M_REG)) u_m_reg (
    .clk_i, .rst_ni, .ce_i(ce_m_i), .srst_i(srst_m_i), .d_i(m_d), .q_o(m_q)
  );

  assign post_sub = m_q.post_sub;
  assign post_cin = m_q.cin;
  assign post_x   = m_q.xsel;
  assign post_z   = m_q.zsel;

  mac_postadd u_postadd (
    .xsel_i(post_x), .zsel_i(post_z), .sub_i(post_sub), .cin_i(post_cin),
    .prod_i(m_q.prod), .cat_i(m_q.cat), .c_i(m_q.c), .pcin_i,
    .p_i(p_q), .s_o(sum)
  );

  // output stage is always present: it closes the accumulate loop
  mac_pipe_reg #(.W(ACW), .EN(1'b1)) u_p_reg (
    .clk_i, .rst_ni, .ce_i(ce_p_i), .srst_i(srst_p_i), .d_i(sum), .q_o(p_q)
  );

  assign p_o     = p_q;
  assign pcout_o = p_q;
endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk
  import mac_pkg::*;
#(
  parameter bit IN_REG = 1'b1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ce_in_i,
  input logic           srst_in_i,
  input logic           ce_p_i,
  input logic           srst_p_i,
  input logic [OPW-1:0] bcout_o,
  input logic [ACW-1:0] p_o,
  input xsel_e          post_x,
  input zsel_e          post_z,
  input logic           post_sub,
  input logic           post_cin
);
  p_reset_r14: assert property (@(posedge clk_i) !rst_ni |-> (p_o == '0));

  p_p_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_p_i && !srst_p_i) |=> $stable(p_o));

  p_p_clear_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_p_i |=> (p_o == '0));

  p_acc_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_p_i && !srst_p_i && post_x == X_ZERO && post_z == Z_P && !post_sub && !post_cin)
    |=> $stable(p_o));

  if (IN_REG) begin : g_in_chk
    p_b_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ce_in_i && !srst_in_i) |=> $stable(bcout_o));
  end
endmodule

bind mac_slice mac_slice_chk #(.IN_REG(IN_REG)) u_chk (
  .clk_i, .rst_ni, .ce_in_i, .srst_in_i, .ce_p_i, .srst_p_i,
  .bcout_o, .p_o, .post_x, .post_z, .post_sub, .post_cin
);

// File: tb/sim_mac_slice.sv
`timescale 1ns/1ps
module sim_mac_slice;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_in = 1'b1, ce_m = 1'b1, ce_p = 1'b1;
  logic srst_in = 1'b0, srst_m = 1'b0, srst_p = 1'b0;
  logic [6:0]  mode = '0;
  logic [17:0] a = '0, b = '0, d = '0;
  logic [47:0] c = '0, pcin;
  logic        carry = 1'b0;
  logic [17:0] bcout;
  logic [47:0] p, pcout;

  localparam logic [47:0] PCIN_K = 48'h1234_5678_9ABC;
  assign pcin = PCIN_K;

  always #2 clk = ~clk;

  mac_slice u0 (
    .clk_i(clk), .rst_ni, .ce_in_i(ce_in), .ce_m_i(ce_m), .ce_p_i(ce_p),
    .srst_in_i(srst_in), .srst_m_i(srst_m), .srst_p_i(srst_p),
    .mode_i(mode), .a_i(a), .b_i(b), .d_i(d), .c_i(c), .carry_i(carry),
    .pcin_i(pcin), .bcout_o(bcout), .p_o(p), .pcout_o(pcout)
  );

  int n_chk = 0, n_fail = 0;
  logic [47:0] exp_q[$];
  string       tag_q[$];
  logic        issue = 1'b0;
  logic [2:0]  vld_sr = '0;
  logic [47:0] m_p = '0;
  bit          done = 1'b0;

  task automatic check(input logic [47:0] act, input logic [47:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // reference from requirements: mode [1:0]=X, [3:2]=Z, 4 pre_en, 5 pre_sub, 6 post_sub
  function automatic logic [47:0] model(input logic [6:0] md, input logic signed [17:0] fa,
      input logic signed [17:0] fb, input logic signed [17:0] fd, input logic [47:0] fc,
      input logic ci, input logic [47:0] pp);
    logic signed [17:0] bm;
    logic signed [47:0] pr, wa, wb;
    logic [47:0] xv, zv;
    bm = md[4] ? (md[5] ? 18'(fd - fb) : 18'(fd + fb)) : fb;
    wa = fa; wb = bm;
    pr = wa * wb;
    case (md[1:0])
      2'd1: xv = pr;
      2'd2: xv = pp;
      2'd3: xv = {fd[11:0], fa, fb};
      default: xv = '0;
    endcase
    case (md[3:2])
      2'd1: zv = PCIN_K;
      2'd2: zv = pp;
      2'd3: zv = fc;
      default: zv = '0;
    endcase
    return md[6] ? (zv - xv - {47'b0, ci}) : (zv + xv + {47'b0, ci});
  endfunction

  task automatic put(input logic [6:0] md, input logic [17:0] ta, input logic [17:0] tb,
      input logic [17:0] td, input logic [47:0] tc, input logic ci, input string tag);
    logic [47:0] e;
    mode = md; a = ta; b = tb; d = td; c = tc; carry = ci;
    e = model(md, ta, tb, td, tc, ci, m_p);
    m_p = e;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    issue = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) vld_sr <= {vld_sr[1:0], issue};

  // monitor: R11 result lands three edges after issue
  always @(negedge clk) begin
    if (rst_ni && vld_sr[2] && exp_q.size() > 0) begin
      string t;
      logic [47:0] e;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(p, e, {t, "/R11"});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: got hang expected completion");
    n_chk++; n_fail++;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(p, '0, "R14 p");
    check({30'b0, bcout}, '0, "R14 bcout");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    put(7'h01, -18'sd3, 18'sd7, 18'sd0, '0, 1'b0, "R1 neg");
    put(7'h01, 18'h20000, 18'h20000, 18'd9, '0, 1'b0, "R1 min*min R4");
    put(7'h11, 18'sd2, -18'sd30, 18'sd100, '0, 1'b0, "R2 add");
    put(7'h11, 18'sd1, 18'sd1, 18'h1FFFF, '0, 1'b0, "R2 wrap");
    put(7'h31, 18'sd1000, 18'sd9, 18'sd5, '0, 1'b0, "R3 sub");
    put(7'h01, 18'sd5, 18'sd6, 18'h3ABCD, '0, 1'b0, "R4 d ignored");
    put(7'h03, 18'h2AAAA, 18'h15555, 18'h0ABC, '0, 1'b0, "R7 cat");
    put(7'h0C, 18'd0, 18'd0, 18'd0, 48'd123, 1'b0, "R8 c");
    put(7'h04, 18'd0, 18'd0, 18'd0, 48'd1, 1'b0, "R8 pcin");
    put(7'h01, 18'd4, 18'd4, 18'd0, '0, 1'b1, "R9 carry");
    put(7'h4D, 18'd2, 18'd3, 18'd0, 48'd1000, 1'b1, "R5 sub");
    put(7'h01, 18'd1, 18'd1, 18'd0, '0, 1'b0, "R6 seed");
    for (int i = 2; i < 6; i++)
      put(7'h09, 18'(i), 18'd10, 18'd0, '0, 1'b0, "R6 acc");
    put(7'h0D, 18'd1, 18'd1, 18'd0, 48'hFFFF_FFFF_FFFF, 1'b0, "R12 wrap up");
    put(7'h41, 18'd1, 18'd1, 18'd0, '0, 1'b0, "R12 wrap down");
    issue = 1'b0;
    repeat (5) @(negedge clk);

    // clock enable hold and synchronous clear on the output stage
    mode = 7'h0C; c = 48'd5; carry = 1'b0;
    repeat (4) @(negedge clk);
    check(p, 48'd5, "R8 c settle");
    ce_p = 1'b0; c = 48'd77;
    repeat (3) @(negedge clk);
    check(p, 48'd5, "R13 ce hold");
    check(pcout, 48'd5, "R10 pcout");
    ce_p = 1'b1;
    @(negedge clk);
    check(p, 48'd77, "R13 ce resume");
    srst_p = 1'b1; ce_p = 1'b0;
    @(negedge clk);
    srst_p = 1'b0;
    check(p, 48'd0, "R13 srst");
    check(pcout, 48'd0, "R10 pcout clear");
    ce_p = 1'b1;

    // B cascade output and input-stage enable
    mode = 7'h10; d = 18'd5; b = 18'd3;
    @(negedge clk);
    check({30'b0, bcout}, 48'd8, "R10 bcout");
    ce_in = 1'b0; b = 18'd100;
    repeat (2) @(negedge clk);
    check({30'b0, bcout}, 48'd8, "R13 in hold");
    ce_in = 1'b1;
    @(negedge clk);
    check({30'b0, bcout}, 48'd105, "R2 bcout");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule